// File: doc/BRIEF.md
# Overlay-Aware Translation Buffer with Per-Line Steering

This block is a small fully associative translation buffer. Each entry stores an address-space ID, a virtual page number, a physical page number, a copy-on-write flag and a 64-bit presence vector with one bit per 64-byte line of a 4 KB page. A lookup picks the entry whose ID and page number both match the request. It then returns the cache-tag address for the accessed line. If that line's bit is set, the result is the line's address in overlay space: a set top bit, then the 15-bit ID, then the 48-bit virtual address. If the bit is clear, the result is the regular physical page with the page offset.

A write to a clear line of a copy-on-write page is an overlaying write. For such a write the buffer still returns the physical address, and it also raises a one-cycle remap request that carries the overlay page number and the line index. The bit itself is set later, when the remap snoop for that line arrives. The snoop sets one bit in a cached entry and does not invalidate the entry. A separate clear input empties a whole page's vector once its overlay has been merged or dropped. Entries are loaded through a fill port. A fill whose tag is already cached rewrites that entry in place. Any other fill takes a round-robin victim.

Top module: `ovt_tlb`

## Requirements
- R1: During reset and after it, every output is zero and no entry is valid, so the first lookup after reset misses.
- R2: A lookup is answered exactly one clock later. On a miss, rsp_valid=1, rsp_miss=1, rsp_addr=0, rsp_ovl=0 and there is no remap request. In a cycle without a lookup, rsp_valid=0 and every other output is 0.
- R3: An entry hits only if both its ID and its page number (vaddr[47:12]) match. The line index is vaddr[11:6]. If that line's vector bit is clear, rsp_addr = {1'b0, ppn[50:0], vaddr[11:0]} and rsp_ovl=0.
- R4: On a hit whose line bit is set, reads and writes alike give rsp_addr = {1'b1, asid[14:0], vaddr[47:0]} with rsp_ovl=1, and raise no remap request.
- R5: A write that hits a copy-on-write entry with a clear line bit returns the R3 address and also pulses rmp_valid for one cycle, with rmp_opn = {1'b1, asid, vpn} and rmp_line = vaddr[11:6]. The vector bit stays clear.
- R6: A write with a clear line bit to an entry whose copy-on-write flag is 0 is an ordinary physical access and raises no remap request.
- R7: A snoop whose ID and page number match a valid entry sets only the named line's bit. The entry stays valid and its other bits are unchanged. A snoop that matches no entry has no effect.
- R8: A clear whose ID and page number match a valid entry zeroes that entry's whole vector. The entry stays valid, so its lines translate to the physical page again.
- R9: A fill whose ID and page number match a valid entry overwrites that entry and does not move the victim pointer. Any other fill writes the entry under the pointer, which starts at entry 0 and advances by one with wrap-around. At most one entry ever matches a lookup.
- R10: A lookup sees the entry state from before any update in the same cycle. When updates coincide on one entry, the clear overrides the snoop and the fill overrides both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write |
| lk_asid | input | 15 | Address-space ID of the lookup |
| lk_vaddr | input | 48 | Virtual address of the lookup |
| fl_valid | input | 1 | Fill request |
| fl_asid | input | 15 | Fill ID |
| fl_vpn | input | 36 | Fill virtual page number |
| fl_ppn | input | 51 | Fill physical page number |
| fl_cow | input | 1 | Fill copy-on-write flag |
| fl_vec | input | 64 | Fill line presence vector |
| sn_valid | input | 1 | Single-line remap snoop |
| sn_asid | input | 15 | Snoop ID |
| sn_vpn | input | 36 | Snoop virtual page number |
| sn_line | input | 6 | Line whose bit the snoop sets |
| cl_valid | input | 1 | Vector clear request |
| cl_asid | input | 15 | Clear ID |
| cl_vpn | input | 36 | Clear virtual page number |
| rsp_valid | output | 1 | Lookup response present |
| rsp_miss | output | 1 | Lookup missed |
| rsp_ovl | output | 1 | Address lies in overlay space |
| rsp_addr | output | 64 | Cache-tag address |
| rmp_valid | output | 1 | Overlaying-write remap request |
| rmp_opn | output | 52 | Overlay page number of the request |
| rmp_line | output | 6 | Line index of the request |

## Verification
The bench sweeps reads over all 64 lines of a page whose vector has a sparse bit pattern, which shows whether each line is steered by its own bit. Writes are tried in three cases: to set bits, to clear bits of copy-on-write pages and to clear bits of ordinary pages, which separates plain overlay writes, overlaying writes and physical writes. Lookups with the same page number under a different ID show that the ID takes part in matching. Snoops, clears and fills are issued alone, together in one cycle, and alongside a lookup, which checks the update order and that a lookup sees only the earlier state. A run of fills to new pages wraps the victim pointer, and a refill of a page that is already cached shows that such a refill reuses its entry and does not advance the pointer.

// File: rtl/ovt_pkg.sv
package ovt_pkg;
  parameter int VA_W   = 48;
  parameter int ASID_W = 15;
  parameter int PAGE_W = 12;
  parameter int LINE_W = 6;
  localparam int PA_W   = 1 + ASID_W + VA_W;
  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int PPN_W  = PA_W - 1 - PAGE_W;
  localparam int LIDX_W = PAGE_W - LINE_W;
  localparam int LINES  = 1 << LIDX_W;
  localparam int OPN_W  = 1 + ASID_W + VPN_W;
endpackage

// File: rtl/ovt_match.sv
module ovt_match
  import ovt_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic [ENTRIES-1:0]             vld,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid_tab,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_tab,
  input  logic [ASID_W-1:0]              key_asid,
  input  logic [VPN_W-1:0]               key_vpn,
  output logic [ENTRIES-1:0]             hitv
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hitv[g] = vld[g] && (asid_tab[g] == key_asid) && (vpn_tab[g] == key_vpn);
  end
endmodule

// File: rtl/ovt_rr.sv
module ovt_rr #(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr_q
);
  logic [IDX_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_d = '0;
      else                              ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/ovt_entry.sv
module ovt_entry
  import ovt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fl_we,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [PPN_W-1:0]  fl_ppn,
  input  logic              fl_cow,
  input  logic [LINES-1:0]  fl_vec,
  input  logic              sn_we,
  input  logic [LIDX_W-1:0] sn_line,
  input  logic              cl_we,
  output logic              vld_q,
  output logic [ASID_W-1:0] asid_q,
  output logic [VPN_W-1:0]  vpn_q,
  output logic [PPN_W-1:0]  ppn_q,
  output logic              cow_q,
  output logic [LINES-1:0]  vec_q
);
  logic [LINES-1:0] vec_d;

  // order: snoop, then clear, then fill
  always_comb begin
    vec_d = vec_q;
    if (sn_we) vec_d[sn_line] = 1'b1;
    if (cl_we) vec_d = '0;
    if (fl_we) vec_d = fl_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      vec_q <= '0;
    end else begin
      if (fl_we) vld_q <= 1'b1;
      vec_q <= vec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asid_q <= '0;
      vpn_q  <= '0;
      ppn_q  <= '0;
      cow_q  <= 1'b0;
    end else if (fl_we) begin
      asid_q <= fl_asid;
      vpn_q  <= fl_vpn;
      ppn_q  <= fl_ppn;
      cow_q  <= fl_cow;
    end
  end

  AST_SNOOP_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sn_we && !cl_we && !fl_we) |=> vec_q[$past(sn_line)]); // R7
  AST_SNOOP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sn_we && !cl_we && !fl_we) |=> ($countones(vec_q ^ $past(vec_q)) <= 1)); // R7
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_we && !fl_we) |=> (vec_q == '0)); // R8
endmodule

// File: rtl/ovt_tlb.sv
module ovt_tlb
  import ovt_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic              lk_write,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              fl_valid,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [PPN_W-1:0]  fl_ppn,
  input  logic              fl_cow,
  input  logic [LINES-1:0]  fl_vec,
  input  logic              sn_valid,
  input  logic [ASID_W-1:0] sn_asid,
  input  logic [VPN_W-1:0]  sn_vpn,
  input  logic [LIDX_W-1:0] sn_line,
  input  logic              cl_valid,
  input  logic [ASID_W-1:0] cl_asid,
  input  logic [VPN_W-1:0]  cl_vpn,
  output logic              rsp_valid,
  output logic              rsp_miss,
  output logic              rsp_ovl,
  output logic [PA_W-1:0]   rsp_addr,
  output logic              rmp_valid,
  output logic [OPN_W-1:0]  rmp_opn,
  output logic [LIDX_W-1:0] rmp_line
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_in;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_in = rs_q[1];

  logic [ENTRIES-1:0]             e_vld, e_cow;
  logic [ENTRIES-1:0][ASID_W-1:0] e_asid;
  logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
  logic [ENTRIES-1:0][PPN_W-1:0]  e_ppn;
  logic [ENTRIES-1:0][LINES-1:0]  e_vec;
  logic [ENTRIES-1:0]             lk_hitv, fl_hitv, sn_hitv, cl_hitv;
  logic [ENTRIES-1:0]             fl_we, sn_we, cl_we;
  logic [IDX_W-1:0]               rr_ptr, lk_idx;
  logic                           fl_hit, lk_hit;

  ovt_match #(.ENTRIES(ENTRIES)) u_lk_m (.vld(e_vld), .asid_tab(e_asid), .vpn_tab(e_vpn),
    .key_asid(lk_asid), .key_vpn(lk_vaddr[VA_W-1:PAGE_W]), .hitv(lk_hitv));
  ovt_match #(.ENTRIES(ENTRIES)) u_fl_m (.vld(e_vld), .asid_tab(e_asid), .vpn_tab(e_vpn),
    .key_asid(fl_asid), .key_vpn(fl_vpn), .hitv(fl_hitv));
  ovt_match #(.ENTRIES(ENTRIES)) u_sn_m (.vld(e_vld), .asid_tab(e_asid), .vpn_tab(e_vpn),
    .key_asid(sn_asid), .key_vpn(sn_vpn), .hitv(sn_hitv));
  ovt_match #(.ENTRIES(ENTRIES)) u_cl_m (.vld(e_vld), .asid_tab(e_asid), .vpn_tab(e_vpn),
    .key_asid(cl_asid), .key_vpn(cl_vpn), .hitv(cl_hitv));

  assign fl_hit = |fl_hitv;
  assign lk_hit = |lk_hitv;

  ovt_rr #(.ENTRIES(ENTRIES)) u_rr (.clk(clk), .rst_n(rst_in),
    .adv(fl_valid && !fl_hit), .ptr_q(rr_ptr));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign fl_we[g] = fl_valid && (fl_hit ? fl_hitv[g] : (rr_ptr == IDX_W'(g)));
    assign sn_we[g] = sn_valid && sn_hitv[g];
    assign cl_we[g] = cl_valid && cl_hitv[g];
    ovt_entry u_ent (
      .clk(clk), .rst_n(rst_in), .fl_we(fl_we[g]), .fl_asid(fl_asid), .fl_vpn(fl_vpn),
      .fl_ppn(fl_ppn), .fl_cow(fl_cow), .fl_vec(fl_vec), .sn_we(sn_we[g]),
      .sn_line(sn_line), .cl_we(cl_we[g]), .vld_q(e_vld[g]), .asid_q(e_asid[g]),
      .vpn_q(e_vpn[g]), .ppn_q(e_ppn[g]), .cow_q(e_cow[g]), .vec_q(e_vec[g]));
  end

  always_comb begin
    lk_idx = '0;
    for (int i = 0; i < ENTRIES; i++) if (lk_hitv[i]) lk_idx = lk_idx | IDX_W'(i);
  end

  // lookup next state
  logic [LIDX_W-1:0] lk_line;
  logic              lk_bit;
  logic              d_valid, d_miss, d_ovl, d_rmp;
  logic [PA_W-1:0]   d_addr;
  logic [OPN_W-1:0]  d_opn;
  logic [LIDX_W-1:0] d_line;

  assign lk_line = lk_vaddr[PAGE_W-1:LINE_W];
  assign lk_bit  = e_vec[lk_idx][lk_line];

  always_comb begin
    d_valid = 1'b0; d_miss = 1'b0; d_ovl = 1'b0; d_rmp = 1'b0;
    d_addr  = '0;   d_opn  = '0;   d_line = '0;
    if (lk_valid) begin
      d_valid = 1'b1;
      if (!lk_hit) begin
        d_miss = 1'b1;
      end else if (lk_bit) begin
        d_ovl  = 1'b1;
        d_addr = {1'b1, lk_asid, lk_vaddr};
      end else begin
        d_addr = {1'b0, e_ppn[lk_idx], lk_vaddr[PAGE_W-1:0]};
        if (lk_write && e_cow[lk_idx]) begin
          d_rmp  = 1'b1;
          d_opn  = {1'b1, lk_asid, lk_vaddr[VA_W-1:PAGE_W]};
          d_line = lk_line;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_in) begin
    if (!rst_in) begin
      rsp_valid <= 1'b0; rsp_miss <= 1'b0; rsp_ovl  <= 1'b0; rsp_addr <= '0;
      rmp_valid <= 1'b0; rmp_opn  <= '0;   rmp_line <= '0;
    end else begin
      rsp_valid <= d_valid; rsp_miss <= d_miss; rsp_ovl  <= d_ovl; rsp_addr <= d_addr;
      rmp_valid <= d_rmp;   rmp_opn  <= d_opn;  rmp_line <= d_line;
    end
  end

  AST_MISS_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_in)
    rsp_miss |-> (rsp_valid && rsp_addr == '0 && !rmp_valid && !rsp_ovl)); // R2
  AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_in)
    !lk_valid |=> !rsp_valid); // R2
  AST_OVL_SPACE: assert property (@(posedge clk) disable iff (!rst_in)
    (rsp_valid && !rsp_miss) |-> (rsp_ovl == rsp_addr[PA_W-1])); // R4
  AST_REMAP_PHYS: assert property (@(posedge clk) disable iff (!rst_in)
    rmp_valid |-> (rsp_valid && !rsp_ovl && rmp_opn[OPN_W-1]
                   && rmp_line == rsp_addr[PAGE_W-1:LINE_W])); // R5
  AST_LOOKUP_UNIQUE: assert property (@(posedge clk) disable iff (!rst_in)
    $onehot0(lk_hitv)); // R9
endmodule

// File: tb/test_ovt_tlb.sv
module test_ovt_tlb;
  import ovt_pkg::*;
  localparam int NE = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic lk_valid, lk_write, fl_valid, fl_cow, sn_valid, cl_valid;
  logic [ASID_W-1:0] lk_asid, fl_asid, sn_asid, cl_asid;
  logic [VA_W-1:0]   lk_vaddr;
  logic [VPN_W-1:0]  fl_vpn, sn_vpn, cl_vpn;
  logic [PPN_W-1:0]  fl_ppn;
  logic [LINES-1:0]  fl_vec;
  logic [LIDX_W-1:0] sn_line;
  logic rsp_valid, rsp_miss, rsp_ovl, rmp_valid;
  logic [PA_W-1:0]   rsp_addr;
  logic [OPN_W-1:0]  rmp_opn;
  logic [LIDX_W-1:0] rmp_line;

  int vectors = 0;
  int errors  = 0;

  always #5 clk = ~clk;

  ovt_tlb #(.ENTRIES(NE)) i_ovt_tlb (.*);

  // behavioural reference state
  logic              m_vld [NE];
  logic [ASID_W-1:0] m_asid[NE];
  logic [VPN_W-1:0]  m_vpn [NE];
  logic [PPN_W-1:0]  m_ppn [NE];
  logic              m_cow [NE];
  logic [LINES-1:0]  m_vec [NE];
  int                m_ptr;

  function automatic logic [VA_W-1:0] va(input logic [VPN_W-1:0] p, input int ln, input int off);
    return {p, LIDX_W'(ln), LINE_W'(off)};
  endfunction

  task automatic idle();
    lk_valid = 0; lk_write = 0; lk_asid = '0; lk_vaddr = '0;
    fl_valid = 0; fl_cow = 0; fl_asid = '0; fl_vpn = '0; fl_ppn = '0; fl_vec = '0;
    sn_valid = 0; sn_asid = '0; sn_vpn = '0; sn_line = '0;
    cl_valid = 0; cl_asid = '0; cl_vpn = '0;
  endtask

  task automatic look(input logic [ASID_W-1:0] a, input logic [VA_W-1:0] v, input logic w);
    lk_valid = 1; lk_asid = a; lk_vaddr = v; lk_write = w;
  endtask
  task automatic fill(input logic [ASID_W-1:0] a, input logic [VPN_W-1:0] p,
                      input logic [PPN_W-1:0] pp, input logic c, input logic [LINES-1:0] vec);
    fl_valid = 1; fl_asid = a; fl_vpn = p; fl_ppn = pp; fl_cow = c; fl_vec = vec;
  endtask
  task automatic snoop(input logic [ASID_W-1:0] a, input logic [VPN_W-1:0] p, input int ln);
    sn_valid = 1; sn_asid = a; sn_vpn = p; sn_line = LIDX_W'(ln);
  endtask
  task automatic clr(input logic [ASID_W-1:0] a, input logic [VPN_W-1:0] p);
    cl_valid = 1; cl_asid = a; cl_vpn = p;
  endtask

  // apply current inputs for one clock and compare against the model
  task automatic step(input string tag);
    logic e_valid, e_miss, e_ovl, e_rmp;
    logic [PA_W-1:0] e_addr;
    logic [OPN_W-1:0] e_opn;
    logic [LIDX_W-1:0] e_line;
    int hi, fi;
    e_valid = 0; e_miss = 0; e_ovl = 0; e_rmp = 0; e_addr = '0; e_opn = '0; e_line = '0;
    if (lk_valid) begin
      e_valid = 1;
      hi = -1;
      for (int i = 0; i < NE; i++)
        if (m_vld[i] && m_asid[i] == lk_asid && m_vpn[i] == lk_vaddr[VA_W-1:PAGE_W]) hi = i;
      if (hi < 0) e_miss = 1;
      else if (m_vec[hi][lk_vaddr[PAGE_W-1:LINE_W]]) begin
        e_ovl = 1; e_addr = {1'b1, lk_asid, lk_vaddr};
      end else begin
        e_addr = {1'b0, m_ppn[hi], lk_vaddr[PAGE_W-1:0]};
        if (lk_write && m_cow[hi]) begin
          e_rmp = 1; e_opn = {1'b1, lk_asid, lk_vaddr[VA_W-1:PAGE_W]};
          e_line = lk_vaddr[PAGE_W-1:LINE_W];
        end
      end
    end
    @(posedge clk);
    fi = -1;
    if (fl_valid)
      for (int i = 0; i < NE; i++)
        if (m_vld[i] && m_asid[i] == fl_asid && m_vpn[i] == fl_vpn) fi = i;
    if (sn_valid)
      for (int i = 0; i < NE; i++)
        if (m_vld[i] && m_asid[i] == sn_asid && m_vpn[i] == sn_vpn) m_vec[i][sn_line] = 1'b1;
    if (cl_valid)
      for (int i = 0; i < NE; i++)
        if (m_vld[i] && m_asid[i] == cl_asid && m_vpn[i] == cl_vpn) m_vec[i] = '0;
    if (fl_valid) begin
      if (fi < 0) begin fi = m_ptr; m_ptr = (m_ptr + 1) % NE; end
      m_vld[fi] = 1; m_asid[fi] = fl_asid; m_vpn[fi] = fl_vpn;
      m_ppn[fi] = fl_ppn; m_cow[fi] = fl_cow; m_vec[fi] = fl_vec;
    end
    @(negedge clk);
    vectors++;
    if (rsp_valid !== e_valid || rsp_miss !== e_miss || rsp_ovl !== e_ovl ||
        rsp_addr !== e_addr || rmp_valid !== e_rmp || rmp_opn !== e_opn || rmp_line !== e_line) begin
      errors++;
      $display("FAIL %s: got v%0b m%0b o%0b a=%h r%0b opn=%h ln=%0d exp v%0b m%0b o%0b a=%h r%0b opn=%h ln=%0d",
               tag, rsp_valid, rsp_miss, rsp_ovl, rsp_addr, rmp_valid, rmp_opn, rmp_line,
               e_valid, e_miss, e_ovl, e_addr, e_rmp, e_opn, e_line);
    end
    idle();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got running exp done");
    finish_run();
  end

  localparam logic [ASID_W-1:0] AS_A = 15'd5, AS_X = 15'd6;
  localparam logic [VPN_W-1:0]  VP_A = 36'h123456789, VP_B = 36'h000000042,
                                VP_C = 36'h0000000C3, VP_D = 36'h0000000D4,
                                VP_E = 36'h0000000E5, VP_F = 36'h0000000F6;
  localparam logic [LINES-1:0]  VEC_A = 64'h8000_0100_0000_0008;

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_vld[i] = 0; m_asid[i] = '0; m_vpn[i] = '0; m_ppn[i] = '0; m_cow[i] = 0; m_vec[i] = '0;
    end
    m_ptr = 0;
    idle();
    rst_n = 0;
    repeat (3) begin
      @(negedge clk);
      vectors++;
      if (rsp_valid !== 0 || rsp_miss !== 0 || rsp_ovl !== 0 || rsp_addr !== '0 ||
          rmp_valid !== 0 || rmp_opn !== '0 || rmp_line !== '0) begin
        errors++;
        $display("FAIL R1: got v%0b a=%h r%0b exp all zero", rsp_valid, rsp_addr, rmp_valid);
      end
    end
    rst_n = 1;
    repeat (3) step("R1");
    look(AS_A, va(VP_A, 0, 0), 0); step("R1");
    step("R2");
    look(AS_A, va(VP_A, 5, 8), 1); step("R2");

    fill(AS_A, VP_A, 51'h0ABCDE, 1, VEC_A); step("R9");
    for (int l = 0; l < LINES; l++) begin
      look(AS_A, va(VP_A, l, l), 0); step("R3");
    end
    look(AS_A, va(VP_A, 3, 4), 1);  step("R4");
    look(AS_A, va(VP_A, 7, 0), 1);  step("R5");
    look(AS_A, va(VP_A, 7, 0), 1);  step("R5");
    look(AS_A, va(VP_A, 7, 0), 0);  step("R5");
    look(AS_X, va(VP_A, 3, 0), 0);  step("R3");

    snoop(AS_A, VP_A, 7); step("R7");
    look(AS_A, va(VP_A, 7, 1), 0); step("R7");
    look(AS_A, va(VP_A, 6, 1), 0); step("R7");
    snoop(AS_X, VP_A, 8); step("R7");
    look(AS_A, va(VP_A, 8, 2), 1); step("R7");

    fill(AS_A, VP_B, 51'h777, 0, 64'h0); step("R9");
    look(AS_A, va(VP_B, 2, 9), 1); step("R6");

    clr(AS_A, VP_A); step("R8");
    look(AS_A, va(VP_A, 3, 0), 0); step("R8");
    look(AS_A, va(VP_A, 63, 0), 1); step("R8");
    clr(AS_X, VP_B); step("R8");

    look(AS_A, va(VP_A, 9, 0), 0); snoop(AS_A, VP_A, 9); step("R10");
    look(AS_A, va(VP_A, 9, 0), 0); step("R10");
    snoop(AS_A, VP_A, 10); clr(AS_A, VP_A); step("R10");
    look(AS_A, va(VP_A, 10, 0), 0); step("R10");
    look(AS_A, va(VP_A, 9, 0), 0); step("R10");
    snoop(AS_A, VP_B, 4); fill(AS_A, VP_B, 51'h888, 1, 64'h1); step("R10");
    look(AS_A, va(VP_B, 4, 0), 1); step("R10");
    look(AS_A, va(VP_B, 0, 0), 0); step("R10");

    fill(AS_A, VP_C, 51'h3C, 0, 64'h0); step("R9");
    fill(AS_A, VP_D, 51'h4D, 1, 64'hF0); step("R9");
    fill(AS_A, VP_E, 51'h5E, 0, 64'h0); look(AS_A, va(VP_A, 1, 0), 0); step("R9");
    look(AS_A, va(VP_A, 1, 0), 0); step("R9");
    fill(AS_A, VP_B, 51'h999, 0, 64'h0); step("R9");
    look(AS_A, va(VP_B, 0, 0), 0); step("R9");
    fill(AS_A, VP_F, 51'h6F, 0, 64'h0); step("R9");
    look(AS_A, va(VP_B, 0, 0), 0); step("R9");
    look(AS_A, va(VP_C, 1, 0), 0); step("R9");
    look(AS_A, va(VP_D, 4, 0), 1); step("R4");
    look(AS_A, va(VP_D, 9, 0), 1); step("R5");
    step("R2");
    finish_run();
  end
endmodule